// File: doc/BRIEF.md
# Chainable Serial Setpoint Bank

The block holds four 8-bit setpoints that a host loads over a three-wire serial link made of an active-low select, a serial clock and a data line. The host lowers the select line and clocks in a 10-bit frame, sending the most significant bit first: two channel-address bits, then eight value bits. When the select line rises, the value is written into the setpoint of the addressed channel. Every bit that enters the frame register leaves it again ten serial clocks later on a serial output. Several blocks can therefore share one host data line in a chain, with the select line held low until every block in the chain holds its own frame.

An active-low preset input returns all four setpoints to midscale (0x80) and clears the serial output. An active-low sleep input forces the serial output high, raises a sleep status output and leaves the setpoints as they are. A system clock samples all serial and control inputs, which are synchronous to it. Edges of the serial clock and of the select line are found by comparing each input with its value one system clock earlier.

Top module: `serial_trim_bank`

## Requirements
- R1: After system reset every channel reads 0x80, `sdo` is low and `sleep_o` is low.
- R2: While `cs_n` is low, each rising edge of `sclk` shifts `sdi` into a 10-bit frame register. The frame is sent as address bit 1, address bit 0, then value bits 7 down to 0.
- R3: On a rising edge of `cs_n`, the value in the low eight bits of the frame register is written to the channel that the top two bits select: 0 selects channel 0 (`chan_o[7:0]`), 1 selects channel 1 (`chan_o[15:8]`), 2 selects channel 2 (`chan_o[23:16]`) and 3 selects channel 3 (`chan_o[31:24]`). The new value is visible one system clock after the edge is sampled.
- R4: A write leaves the three channels that are not addressed unchanged.
- R5: When more than ten bits are shifted during one select-low period, only the last ten are used.
- R6: After each falling edge of `sclk` while `cs_n` is low, `sdo` carries the bit that was shifted in nine rising edges before the latest one. A second block whose `sdi` is driven by `sdo` therefore captures exactly the first ten bits of a 20-bit stream.
- R7: While `mid_n` is low, every channel is set to 0x80 and `sdo` is driven low. This takes priority over a write started by the select line.
- R8: While `sleep_n` is low, `sdo` is high and `sleep_o` is high. Channels keep their values unless a write is committed. Once sleep ends, `sdo` again shows the frame register's top bit.
- R9: While `cs_n` is high, activity on `sclk` and `sdi` changes neither the frame register nor `sdo` nor any channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| cs_n | input | 1 | Active-low select; its rising edge commits a frame |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| mid_n | input | 1 | Active-low preset to midscale |
| sleep_n | input | 1 | Active-low sleep |
| sdo | output | 1 | Serial chain output, high during sleep |
| sleep_o | output | 1 | Sleep status |
| chan_o | output | 32 | Four 8-bit setpoints, channel 0 in the low byte |

## Verification
The assertions assume that every input is synchronous to `clk` and holds each level for at least one system clock. If an input changed between clock samples, an edge of `sclk` or `cs_n` could be missed. The bench changes inputs only on falling edges of `clk` and holds each serial clock phase and each select transition for two system clocks. It changes the select line only while `sclk` is low, so the assumed serial clock edges and select edges always appear as separate, well-formed events.

// File: rtl/serial_trim_bank.sv
module serial_trim_bank #(
  parameter int AW = 2,
  parameter int DW = 8,
  localparam int NCH = 1 << AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              mid_n,
  input  logic              sleep_n,
  output logic              sdo,
  output logic              sleep_o,
  output logic [NCH*DW-1:0] chan_o
);
  localparam int FW = AW + DW;
  localparam logic [DW-1:0] MID = DW'(1) << (DW - 1);

  logic          cs_q, sclk_q, sdo_q;
  logic [FW-1:0] sr;
  logic [DW-1:0] lat [NCH];
  logic [AW-1:0] addr;
  logic          s_rise, s_fall, cs_rise;

  assign s_rise  = ~cs_n & sclk & ~sclk_q;
  assign s_fall  = ~cs_n & ~sclk & sclk_q;
  assign cs_rise = cs_n & ~cs_q;
  assign addr    = sr[FW-1:DW];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      cs_q   <= cs_n;
      sclk_q <= sclk;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      sr <= '0;
    else if (s_rise) sr <= {sr[FW-2:0], sdi};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      sdo_q <= 1'b0;
    else if (!mid_n) sdo_q <= 1'b0;
    else if (s_fall) sdo_q <= sr[FW-1];

  assign sdo     = sleep_n ? sdo_q : 1'b1;
  assign sleep_o = ~sleep_n;

  assert_shift_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
    s_rise |=> sr == {$past(sr[FW-2:0]), $past(sdi)});
  assert_idle_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> $stable(sr));
  assert_idle_sdo_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && mid_n) |=> $stable(sdo_q));
  assert_midscale_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mid_n |=> (chan_o == {NCH{MID}}) && !sdo_q);
  assert_sleep_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_n && mid_n && !cs_rise) |=> $stable(chan_o));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                          lat[i] <= MID;
      else if (!mid_n)                     lat[i] <= MID;
      else if (cs_rise && addr == AW'(i))  lat[i] <= sr[DW-1:0];

    assign chan_o[i*DW +: DW] = lat[i];

    assert_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_rise && mid_n && addr == AW'(i)) |=> lat[i] == $past(sr[DW-1:0]));
    assert_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mid_n && !(cs_rise && addr == AW'(i))) |=> $stable(lat[i]));
  end
endmodule

// File: tb/tb_serial_trim_bank.sv
`timescale 1ns/1ps
module tb_serial_trim_bank;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic mid_n = 1'b1, sleep_n = 1'b1;
  wire        sdo, sleep_o, sdo_b, sleep_b;
  wire [31:0] chan, chan_b;

  serial_trim_bank dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .mid_n(mid_n), .sleep_n(sleep_n), .sdo(sdo), .sleep_o(sleep_o), .chan_o(chan));
  serial_trim_bank dut_b (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdo),
    .mid_n(mid_n), .sleep_n(1'b1), .sdo(sdo_b), .sleep_o(sleep_b), .chan_o(chan_b));

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  logic [7:0] exp_ch [4];
  logic [9:0] hist = '0;
  bit done = 0;

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] exp_vec();
    return {exp_ch[3], exp_ch[2], exp_ch[1], exp_ch[0]};
  endfunction

  task automatic shift_bit(bit b, bit chk);
    sdi = b; sclk = 1'b1; wait_n(2);
    hist = {hist[8:0], b};
    sclk = 1'b0; wait_n(2);
    if (chk) check(sdo == hist[9], "R6", "sdo after fall", 32'(sdo), 32'(hist[9]));
  endtask

  task automatic shift_frame(logic [1:0] a, logic [7:0] v);
    logic [9:0] f;
    f = {a, v};
    for (int i = 9; i >= 0; i--) shift_bit(f[i], 1'b1);
  endtask

  task automatic send(logic [1:0] a, logic [7:0] v, int lead);
    cs_n = 1'b0; wait_n(2);
    for (int i = 0; i < lead; i++) shift_bit(i[0], 1'b1);
    shift_frame(a, v);
    cs_n = 1'b1; wait_n(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) exp_ch[i] = 8'h80;
    wait_n(3); rst_n = 1'b1; wait_n(2);
    check(chan == 32'h80808080, "R1", "reset channels", chan, 32'h80808080);
    check(sdo == 1'b0, "R1", "reset sdo", 32'(sdo), 0);
    check(sleep_o == 1'b0, "R1", "reset sleep", 32'(sleep_o), 0);

    // R2 R3 R4: every value on every channel, scrambled order
    for (int a = 0; a < 4; a++)
      for (int v = 0; v < 256; v++) begin
        logic [7:0] val;
        val = 8'((v * 37 + a * 11) & 255);
        send(2'(a), val, 0);
        exp_ch[a] = val;
        check(chan == exp_vec(), "R2 R3 R4", "write", chan, exp_vec());
      end

    // R5: leading junk bits are discarded
    send(2'd2, 8'h5A, 5);
    exp_ch[2] = 8'h5A;
    check(chan == exp_vec(), "R5", "long frame", chan, exp_vec());

    // R9: clocking with select high does nothing
    sdi = 1'b1;
    for (int i = 0; i < 12; i++) begin
      sclk = 1'b1; wait_n(2); sclk = 1'b0; wait_n(2);
    end
    check(chan == exp_vec(), "R9", "idle channels", chan, exp_vec());
    check(sdo == hist[9], "R9", "idle sdo", 32'(sdo), 32'(hist[9]));
    cs_n = 1'b0; wait_n(2); cs_n = 1'b1; wait_n(2);
    check(chan == exp_vec(), "R9", "frame kept", chan, exp_vec());

    // R7: preset to midscale
    mid_n = 1'b0; wait_n(2);
    check(chan == 32'h80808080, "R7", "preset channels", chan, 32'h80808080);
    check(sdo == 1'b0, "R7", "preset sdo", 32'(sdo), 0);
    mid_n = 1'b1; wait_n(2);
    for (int i = 0; i < 4; i++) exp_ch[i] = 8'h80;
    cs_n = 1'b0; wait_n(2);
    shift_frame(2'd1, 8'h33);
    mid_n = 1'b0; cs_n = 1'b1; wait_n(2);
    mid_n = 1'b1; wait_n(2);
    check(chan == exp_vec(), "R7", "preset beats write", chan, exp_vec());

    // R8: sleep
    send(2'd3, 8'hC4, 0);
    exp_ch[3] = 8'hC4;
    sleep_n = 1'b0; wait_n(2);
    check(sdo == 1'b1, "R8", "sleep sdo", 32'(sdo), 1);
    check(sleep_o == 1'b1, "R8", "sleep status", 32'(sleep_o), 1);
    cs_n = 1'b0; wait_n(2);
    shift_bit(1'b0, 1'b0);
    check(sdo == 1'b1, "R8", "sleep sdo shifting", 32'(sdo), 1);
    shift_bit(1'b1, 1'b0);
    shift_bit(1'b0, 1'b0);
    check(sdo == 1'b1, "R8", "sleep sdo shifting", 32'(sdo), 1);
    check(chan == exp_vec(), "R8", "sleep channels kept", chan, exp_vec());
    sleep_n = 1'b1; wait_n(2);
    check(sleep_o == 1'b0, "R8", "wake status", 32'(sleep_o), 0);
    check(sdo == hist[9], "R8", "wake sdo", 32'(sdo), 32'(hist[9]));
    cs_n = 1'b1; wait_n(2);
    exp_ch[hist[9:8]] = hist[7:0];
    check(chan == exp_vec(), "R8", "commit after wake", chan, exp_vec());

    // R6: two-block chain, 20-bit stream
    for (int k = 0; k < 4; k++) begin
      logic [1:0] a1, a2;
      logic [7:0] v1, v2;
      a1 = 2'(k); a2 = 2'(3 - k);
      v1 = 8'(8'h1F + k * 53); v2 = 8'(8'hE2 - k * 29);
      cs_n = 1'b0; wait_n(2);
      shift_frame(a1, v1);
      shift_frame(a2, v2);
      cs_n = 1'b1; wait_n(2);
      exp_ch[a2] = v2;
      check(chan == exp_vec(), "R6", "upstream frame", chan, exp_vec());
      check(chan_b[a1*8 +: 8] == v1, "R6", "downstream frame",
            32'(chan_b[a1*8 +: 8]), 32'(v1));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule